// File: doc/BRIEF.md
# Framed Packet Checksum Checker

This block watches a byte stream that arrives one byte per clock on an 8-bit bus. It searches the stream for a two-byte marker. When it finds the marker it takes the next byte as a byte count. It then takes that many body bytes, followed by one closing check byte. While the body goes by it adds the body bytes together, modulo 256, and compares that total with the check byte.

The source of the stream changes the byte on the falling clock edge, and the block samples it on the rising edge. The block has two outputs. A body flag is high for exactly the cycles in which a body byte is on the bus. An error flag gives a single-cycle pulse when the total and the check byte differ.

The block keeps no copy of the body. Once the check byte has been sampled, it goes straight back to searching for the marker.

Top module: `frame_sum_checker`

## Requirements
- R1: While reset is high, and in the cycle after a reset edge, `body_valid` and `sum_error` are both low. The block then searches for the first marker byte, and its running total is zero.
- R2: A frame starts only when 0x33 is sampled and 0xCC is sampled on the very next edge. Bytes sampled while searching produce no output: both flags stay low.
- R3: If the byte after a 0x33 is not 0xCC, the search restarts. If that byte is itself 0x33, it counts as a new first marker byte, so the sequence 0x33 0x33 0xCC opens a frame.
- R4: The byte that follows the two marker bytes is the body length N, read as an unsigned number from 0 to 255. When N > 0, `body_valid` is high during exactly the N cycles in which body bytes are on the bus. It goes high at the edge that samples the length byte and low at the edge that samples the last body byte.
- R5: The total is the sum modulo 256 of the body bytes only. When it differs from the check byte, `sum_error` is high for the one cycle that follows the edge sampling the check byte.
- R6: When the total equals the check byte, `sum_error` stays low.
- R7: A length of zero means the next byte is the check byte, compared against a total of 0. `body_valid` stays low for that frame.
- R8: The total is cleared at every new frame. After the check byte the block searches for 0x33 at once, so frames may follow each other with no gap.
- R9: `sum_error` is never high in two consecutive cycles, and it is never high in the same cycle as `body_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. The stream is sampled on its rising edge. |
| rst | input | 1 | Synchronous reset, active high |
| rx_byte | input | 8 | Incoming stream byte. It changes on the falling edge. |
| body_valid | output | 1 | High while a body byte is on the bus |
| sum_error | output | 1 | One-cycle pulse on a check byte mismatch |

## Verification
A wrong phase shows at the ports within one byte:
- a missed or false marker match, or a wrong length load, makes `body_valid` rise a cycle early, rise a cycle late or not rise at all;
- a wrong remaining count moves the falling edge of `body_valid`.

A total that is not cleared, or one that takes in the length or check byte, stays hidden until the check byte. At that point `sum_error` pulses when it should not, or fails to pulse.

The bench therefore compares both flags against its own model on every cycle. Its frames are built so that a stale total, a sum that wraps past 255, and a zero length each change the value of `sum_error`.

// File: rtl/frame_sum_pkg.sv
package frame_sum_pkg;

    typedef enum logic [2:0] {
        PH_SEEK_A,
        PH_SEEK_B,
        PH_COUNT,
        PH_BODY,
        PH_CHECK
    } phase_t;

    typedef struct packed {
        logic hit_a;
        logic hit_b;
        logic zero_len;
        logic last_body;
    } cues_t;

    typedef struct packed {
        logic body;
        logic err;
    } flags_t;

    function automatic phase_t next_phase(input phase_t cur, input cues_t c);
        phase_t nxt;
        nxt = cur;
        case (cur)
            PH_SEEK_A: nxt = c.hit_a ? PH_SEEK_B : PH_SEEK_A;
            PH_SEEK_B: nxt = c.hit_b ? PH_COUNT : (c.hit_a ? PH_SEEK_B : PH_SEEK_A);
            PH_COUNT:  nxt = c.zero_len ? PH_CHECK : PH_BODY;
            PH_BODY:   nxt = c.last_body ? PH_CHECK : PH_BODY;
            PH_CHECK:  nxt = PH_SEEK_A;
            default:   nxt = PH_SEEK_A;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/frame_sum_ctrl.sv
module frame_sum_ctrl
    import frame_sum_pkg::*;
#(
    parameter int          DW     = 8,
    parameter logic [DW-1:0] MARK_A = 8'h33,
    parameter logic [DW-1:0] MARK_B = 8'hCC
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] din,
    input  logic          last_body,
    output phase_t        phase
);

    cues_t cues;

    always_comb begin
        cues.hit_a     = (din == MARK_A);
        cues.hit_b     = (din == MARK_B);
        cues.zero_len  = (din == '0);
        cues.last_body = last_body;
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_SEEK_A;
        else     phase <= next_phase(phase, cues);
    end

    // R2
    seek_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SEEK_A && din != MARK_A) |=> (phase == PH_SEEK_A));

    // R3
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SEEK_B && din == MARK_A) |=> (phase == PH_SEEK_B));

endmodule

// File: rtl/frame_sum_acc.sv
module frame_sum_acc
    import frame_sum_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  phase_t        phase,
    input  logic [DW-1:0] din,
    output logic          last_body,
    output logic          mismatch
);

    localparam logic [DW-1:0] ONE = DW'(1);

    logic [DW-1:0] total;
    logic [DW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            total  <= '0;
            remain <= '0;
        end else begin
            case (phase)
                PH_COUNT: begin
                    total  <= '0;
                    remain <= din;
                end
                PH_BODY: begin
                    total  <= total + din;
                    remain <= remain - ONE;
                end
                default: ;
            endcase
        end
    end

    assign last_body = (remain == ONE);
    assign mismatch  = (total != din);

    // R4
    body_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_BODY) |-> (remain != '0));

    // R8
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_COUNT) |=> (total == '0));

endmodule

// File: rtl/frame_sum_checker.sv
module frame_sum_checker
    import frame_sum_pkg::*;
#(
    parameter int            DW     = 8,
    parameter logic [DW-1:0] MARK_A = 8'h33,
    parameter logic [DW-1:0] MARK_B = 8'hCC
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] rx_byte,
    output logic          body_valid,
    output logic          sum_error
);

    phase_t phase;
    logic   last_body;
    logic   mismatch;
    flags_t flags;

    frame_sum_ctrl #(.DW(DW), .MARK_A(MARK_A), .MARK_B(MARK_B)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .din       (rx_byte),
        .last_body (last_body),
        .phase     (phase)
    );

    frame_sum_acc #(.DW(DW)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .phase     (phase),
        .din       (rx_byte),
        .last_body (last_body),
        .mismatch  (mismatch)
    );

    always_ff @(posedge clk) begin
        if (rst) flags.err <= 1'b0;
        else     flags.err <= (phase == PH_CHECK) && mismatch;
    end

    assign flags.body = (phase == PH_BODY);
    assign body_valid = flags.body;
    assign sum_error  = flags.err;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!body_valid && !sum_error));

    // R9
    err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        sum_error |=> !sum_error);

    // R9
    err_body_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(sum_error && body_valid));

    // R7
    zero_len_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_COUNT && rx_byte == '0) |=> !body_valid);

endmodule

// File: tb/frame_sum_checker_tb.sv
module frame_sum_checker_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] rx_byte = 8'h00;
    logic       body_valid;
    logic       sum_error;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;
    string tag = "R1";

    // behavioural model state
    int       m_step = 0;
    int       m_left = 0;
    byte      m_body[$];
    bit       exp_v = 0;
    bit       exp_e = 0;

    frame_sum_checker u_dut (
        .clk        (clk),
        .rst        (rst),
        .rx_byte    (rx_byte),
        .body_valid (body_valid),
        .sum_error  (sum_error)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        int s;
        cycles++;
        exp_e = 0;
        if (rst) begin
            m_step = 0;
            m_body.delete();
        end else begin
            case (m_step)
                0: if (rx_byte == 8'h33) m_step = 1;
                1: if (rx_byte == 8'hCC) m_step = 2;
                   else if (rx_byte != 8'h33) m_step = 0;
                2: begin
                    m_left = rx_byte;
                    m_body.delete();
                    m_step = (m_left == 0) ? 4 : 3;
                end
                3: begin
                    m_body.push_back(rx_byte);
                    m_left--;
                    if (m_left == 0) m_step = 4;
                end
                default: begin
                    s = 0;
                    foreach (m_body[i]) s += int'(m_body[i]) & 255;
                    exp_e = ((s % 256) != int'(rx_byte));
                    m_step = 0;
                end
            endcase
        end
        exp_v = (m_step == 3);
    end

    task automatic compare();
        checks++;
        if (body_valid !== exp_v) begin
            errors++;
            $display("FAIL %s body_valid actual %b expected %b (cycle %0d)", tag, body_valid, exp_v, cycles);
        end
        checks++;
        if (sum_error !== exp_e) begin
            errors++;
            $display("FAIL %s sum_error actual %b expected %b (cycle %0d)", tag, sum_error, exp_e, cycles);
        end
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        compare();
        rx_byte = b;
    endtask

    task automatic frame(input int n, input int seed, input bit good);
        int s = 0;
        put(8'h33);
        put(8'hCC);
        put(8'(n));
        for (int i = 0; i < n; i++) begin
            logic [7:0] b = 8'((seed + i * 37) & 255);
            s += b;
            put(b);
        end
        put(good ? 8'(s) : 8'(s + 1));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) put(8'h5A);
    endtask

    initial begin
        // R1: reset state
        tag = "R1";
        repeat (3) @(negedge clk);
        compare();
        @(negedge clk);
        rst = 1'b0;
        idle(2);

        // R2: noise, lone markers, reversed pair
        tag = "R2";
        put(8'hCC); put(8'h33); put(8'h00); put(8'hCC); put(8'h33); put(8'h33 ^ 8'h01);
        idle(2);

        // R4 and R6: good frame
        tag = "R4";
        frame(3, 17, 1);
        tag = "R6";
        frame(5, 200, 1);
        idle(1);

        // R5: bad frame, and a sum that wraps past 255
        tag = "R5";
        frame(4, 9, 0);
        put(8'h33); put(8'hCC); put(8'h02); put(8'hFF); put(8'h02); put(8'h01);
        put(8'h33); put(8'hCC); put(8'h02); put(8'hFF); put(8'h02); put(8'h00);
        idle(2);

        // R3: repeated first marker, and a broken pair
        tag = "R3";
        put(8'h33); put(8'h33); put(8'hCC); put(8'h01); put(8'h44); put(8'h44);
        put(8'h33); put(8'h12); put(8'hCC); put(8'h02); put(8'h01); put(8'h01);
        idle(2);

        // R7: zero length, good and bad
        tag = "R7";
        frame(0, 0, 1);
        put(8'h33); put(8'hCC); put(8'h00); put(8'h07);
        idle(2);

        // R8 and R9: back-to-back frames, the total must restart each time
        tag = "R8";
        frame(2, 100, 1);
        frame(2, 100, 0);
        frame(2, 100, 1);
        tag = "R9";
        frame(1, 3, 0);
        frame(1, 3, 0);

        // R4: longest body
        tag = "R4";
        frame(255, 1, 1);
        idle(3);

        // R1: reset in the middle of a frame
        tag = "R1";
        put(8'h33); put(8'hCC); put(8'h04); put(8'h10);
        @(negedge clk);
        compare();
        rst = 1'b1;
        @(negedge clk);
        compare();
        rst = 1'b0;
        idle(3);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        if (!done && cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog actual %0d cycles expected under %0d", cycles, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule